// File: doc/BRIEF.md
# Processor Bus Cycle Command Controller

This block sits beside a pipelined processor and turns its bus status lines into timed bus strobes. Its clock runs at twice the processor's internal rate, so each processor state spans two clocks. When one of the two active-low status bits is seen low, the block decodes the cycle type from the memory/IO select and the status pair. It then steps through a status phase, a command phase and wait phases. Along the way it produces an address latch pulse, a cascade enable for interrupt acknowledge, data transceiver enable and direction, and exactly one of five active-low commands.

A strap picks between a fast mode that adds no delay and a bus-standard compatible mode, in which commands start one clock later and write data enable is deferred by one clock. A command-delay input can hold the command off clock by clock. Ready ends the cycle, and a new status may be accepted on the edge that ends the old cycle. A latched select, captured at the end of the status phase, decides whether this controller drives the cycle at all. A dual-function pin is an active-low bus grant with tristate control in compatible mode, and a plain active-high enable in fast mode.

All inputs are sampled and all state changes on the rising edge of `clk`. Edge 0 below means the edge at which a starting status is sampled, and edge n is the nth edge after it.

Top module: `buscmd_ctrl`

## Requirements
- R1: The cycle type comes from {mem_io, st_n[1], st_n[0]}: 000 interrupt acknowledge (iack_n), 001 I/O read (iord_n), 010 I/O write (iowr_n), 101 memory read (mrd_n), 110 memory write (mwr_n). Codes 011 and 111 are idle and 100 is halt. At most one command is low at any time.
- R2: For the five command types, ale is high for exactly the one clock after edge 0. casc_en is high in that same clock only for interrupt acknowledge.
- R3: dir_wr goes low at edge 1 for reads and interrupt acknowledge, and it returns high at the first idle edge after the cycle ends. It is high whenever no cycle is active. den is low in the clock before and the clock after every dir_wr change.
- R4: In fast mode (mode_compat=0), den and the command go active at edge 2, provided hold_cmd is low at edge 2.
- R5: In compatible mode (mode_compat=1), the command goes active at edge 3 at the earliest. den goes active at edge 2 on reads and at edge 3 on writes.
- R6: Each edge that samples hold_cmd high keeps an inactive command inactive. hold_cmd does not affect den, ale or dir_wr.
- R7: rdy_n is sampled from edge 3 onward. Low ends the cycle, and command and den are inactive after that edge. If the command was not yet active, the cycle ends with no command.
- R8: sel_latch is captured at edge 1. If it is low, the cycle has no den and no command, while ale and dir_wr still follow the cycle.
- R9: Compatible mode: en_grant high at an edge makes cmd_oe and den low after it. Fast mode: en_grant low at an edge forces all commands high and den low after it, with cmd_oe staying high.
- R10: Halt and idle codes start no cycle: no ale, no outputs, and hold_cmd, rdy_n and sel_latch are ignored.
- R11: A status seen low on the edge where rdy_n ends a cycle starts the next cycle at once (that edge is its edge 0).
- R12: Synchronous reset (rst high) gives idle: ale, casc_en and den low, all commands high, dir_wr high. cmd_oe is high in fast mode and low in compatible mode until a grant is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, twice the processor rate |
| rst | input | 1 | Synchronous active-high reset |
| st_n | input | 2 | Active-low status {S1,S0} |
| mem_io | input | 1 | 1 memory space, 0 I/O space |
| mode_compat | input | 1 | Strap: 1 compatible timing, 0 fast |
| sel_latch | input | 1 | Controller select, captured at edge 1 |
| hold_cmd | input | 1 | Command delay request, active high |
| rdy_n | input | 1 | Active-low cycle end |
| en_grant | input | 1 | Grant (active low, compatible) or enable (active high, fast) |
| ale | output | 1 | Address latch enable |
| casc_en | output | 1 | Cascade address enable |
| den | output | 1 | Data transceiver enable |
| dir_wr | output | 1 | Transceiver direction, 1 = write |
| cmd_oe | output | 1 | Command output drive enable |
| mrd_n | output | 1 | Memory read command |
| mwr_n | output | 1 | Memory write command |
| iord_n | output | 1 | I/O read command |
| iowr_n | output | 1 | I/O write command |
| iack_n | output | 1 | Interrupt acknowledge command |

## Verification
The hardest situation to reach is a cycle that ends on the same edge that accepts the next status. The old direction must hold through that edge while ale already pulses for the new cycle. The bench gets there by raising ready-low and the new status code together one clock into the command phase of a fast read. A close second is a cycle in compatible mode that ends before its command could start. The bench forces that by giving ready low on the first edge at which ready is sampled.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  localparam int NUM_CMD   = 5;
  localparam int CMD_IACK  = 0;
  localparam int CMD_IORD  = 1;
  localparam int CMD_IOWR  = 2;
  localparam int CMD_MRD   = 3;
  localparam int CMD_MWR   = 4;
  localparam int CODE_W    = 3;

  typedef enum logic [CODE_W-1:0] {
    CY_IACK  = 3'b000,
    CY_IORD  = 3'b001,
    CY_IOWR  = 3'b010,
    CY_NONE0 = 3'b011,
    CY_HALT  = 3'b100,
    CY_MRD   = 3'b101,
    CY_MWR   = 3'b110,
    CY_NONE1 = 3'b111
  } cyc_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STAT = 2'd1,
    ST_CMD  = 2'd2,
    ST_WAIT = 2'd3
  } phase_t;
endpackage

// File: rtl/bcc_decode.sv
module bcc_decode
  import bcc_pkg::*;
(
  input  logic               mem_io,
  input  logic [1:0]         st_n,
  output logic [NUM_CMD-1:0] cmd_sel,
  output logic               is_cmd,
  output logic               is_wr,
  output logic               is_iack,
  output logic               is_halt
);
  cyc_t cyc;
  assign cyc = cyc_t'({mem_io, st_n});

  always_comb begin
    cmd_sel = '0;
    is_cmd  = 1'b0;
    is_wr   = 1'b0;
    is_iack = 1'b0;
    is_halt = 1'b0;
    case (cyc)
      CY_IACK: begin cmd_sel[CMD_IACK] = 1'b1; is_cmd = 1'b1; is_iack = 1'b1; end
      CY_IORD: begin cmd_sel[CMD_IORD] = 1'b1; is_cmd = 1'b1; end
      CY_IOWR: begin cmd_sel[CMD_IOWR] = 1'b1; is_cmd = 1'b1; is_wr = 1'b1; end
      CY_MRD:  begin cmd_sel[CMD_MRD]  = 1'b1; is_cmd = 1'b1; end
      CY_MWR:  begin cmd_sel[CMD_MWR]  = 1'b1; is_cmd = 1'b1; is_wr = 1'b1; end
      CY_HALT: is_halt = 1'b1;
      default: ;
    endcase
  end

  // R1: decoded command selection is never ambiguous
  always_comb begin
    a_r1_dec_onehot: assert ($onehot0(cmd_sel) && (is_cmd == (cmd_sel != '0)));
  end
endmodule

// File: rtl/bcc_seq.sv
module bcc_seq
  import bcc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_compat,
  input  logic               hold_cmd,
  input  logic               rdy_n,
  input  logic               sel_latch,
  input  logic               dec_cmd,
  input  logic               dec_wr,
  input  logic               dec_iack,
  input  logic               dec_halt,
  input  logic [NUM_CMD-1:0] dec_sel,
  output logic               ale,
  output logic               casc_en,
  output logic               dir_wr,
  output logic               cmd_act,
  output logic               den_act,
  output logic [NUM_CMD-1:0] cmd_sel
);
  phase_t state_q;
  logic   wr_q;
  logic   sel_q;

  assign cmd_sel = cmd_sel_q;
  logic [NUM_CMD-1:0] cmd_sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      ale       <= 1'b0;
      casc_en   <= 1'b0;
      dir_wr    <= 1'b1;
      cmd_act   <= 1'b0;
      den_act   <= 1'b0;
      wr_q      <= 1'b1;
      sel_q     <= 1'b0;
      cmd_sel_q <= '0;
    end else begin
      ale     <= 1'b0;
      casc_en <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (dec_cmd) begin
            state_q   <= ST_STAT;
            ale       <= 1'b1;
            casc_en   <= dec_iack;
            wr_q      <= dec_wr;
            cmd_sel_q <= dec_sel;
          end else begin
            dir_wr <= 1'b1;
          end
        end
        ST_STAT: begin
          sel_q   <= sel_latch;
          dir_wr  <= wr_q;
          state_q <= ST_CMD;
        end
        ST_CMD: begin
          state_q <= ST_WAIT;
          if (sel_q && (!mode_compat || !wr_q)) den_act <= 1'b1;
          if (sel_q && !mode_compat && !hold_cmd) cmd_act <= 1'b1;
        end
        ST_WAIT: begin
          if (!rdy_n) begin
            cmd_act <= 1'b0;
            den_act <= 1'b0;
            if (dec_cmd) begin
              state_q   <= ST_STAT;
              ale       <= 1'b1;
              casc_en   <= dec_iack;
              wr_q      <= dec_wr;
              cmd_sel_q <= dec_sel;
            end else begin
              state_q <= ST_IDLE;
            end
          end else if (sel_q) begin
            den_act <= 1'b1;
            if (!hold_cmd) cmd_act <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: cascade enable only accompanies the address latch pulse
  a_r2_casc_with_ale: assert property (@(posedge clk) disable iff (rst)
    casc_en |-> ale);
  // R3: direction moves only while data enable is quiet
  a_r3_dir_quiet: assert property (@(posedge clk) disable iff (rst)
    !$stable(dir_wr) |-> (!den_act && !$past(den_act)));
  // R5: compatible mode never starts a command on the first command edge
  a_r5_compat_late: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CMD && mode_compat) |=> !cmd_act);
  // R6: delay request keeps an idle command idle
  a_r6_hold_blocks: assert property (@(posedge clk) disable iff (rst)
    (!cmd_act && hold_cmd) |=> !cmd_act);
  // R7: ready low in a wait phase ends command and data enable
  a_r7_ready_ends: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && !rdy_n) |=> (!cmd_act && !den_act));
  // R8: deselected cycle drives nothing
  a_r8_desel_quiet: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_CMD || state_q == ST_WAIT) && !sel_q) |=> (!cmd_act && !den_act));
  // R10: halt status starts nothing
  a_r10_halt_ignored: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && dec_halt) |=> (!ale && state_q == ST_IDLE));
endmodule

// File: rtl/bcc_drive.sv
module bcc_drive
  import bcc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_compat,
  input  logic               en_grant,
  input  logic               cmd_act,
  input  logic               den_act,
  input  logic [NUM_CMD-1:0] cmd_sel,
  output logic [NUM_CMD-1:0] cmd_n,
  output logic               den,
  output logic               cmd_oe
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= mode_compat ? ~en_grant : en_grant;
  end

  assign cmd_n  = ~(cmd_sel & {NUM_CMD{cmd_act & en_q}});
  assign den    = den_act & en_q;
  assign cmd_oe = !mode_compat || en_q;

  // R1: never two commands at once
  a_r1_cmd_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cmd_n));
  // R9: withdrawn grant releases the command lines and data enable
  a_r9_tristate: assert property (@(posedge clk) disable iff (rst)
    (mode_compat && en_grant) |=> (!cmd_oe || !mode_compat) && !den);
  // R9: low enable in fast mode forces inactive but driven outputs
  a_r9_force_off: assert property (@(posedge clk) disable iff (rst)
    (!mode_compat && !en_grant) |=> (mode_compat || (cmd_oe && (&cmd_n) && !den)));
endmodule

// File: rtl/buscmd_ctrl.sv
module buscmd_ctrl
  import bcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] st_n,
  input  logic       mem_io,
  input  logic       mode_compat,
  input  logic       sel_latch,
  input  logic       hold_cmd,
  input  logic       rdy_n,
  input  logic       en_grant,
  output logic       ale,
  output logic       casc_en,
  output logic       den,
  output logic       dir_wr,
  output logic       cmd_oe,
  output logic       mrd_n,
  output logic       mwr_n,
  output logic       iord_n,
  output logic       iowr_n,
  output logic       iack_n
);
  logic [NUM_CMD-1:0] dec_sel, cmd_sel, cmd_n;
  logic dec_cmd, dec_wr, dec_iack, dec_halt;
  logic cmd_act, den_act;

  bcc_decode u_dec (
    .mem_io  (mem_io),
    .st_n    (st_n),
    .cmd_sel (dec_sel),
    .is_cmd  (dec_cmd),
    .is_wr   (dec_wr),
    .is_iack (dec_iack),
    .is_halt (dec_halt)
  );

  bcc_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .mode_compat (mode_compat),
    .hold_cmd    (hold_cmd),
    .rdy_n       (rdy_n),
    .sel_latch   (sel_latch),
    .dec_cmd     (dec_cmd),
    .dec_wr      (dec_wr),
    .dec_iack    (dec_iack),
    .dec_halt    (dec_halt),
    .dec_sel     (dec_sel),
    .ale         (ale),
    .casc_en     (casc_en),
    .dir_wr      (dir_wr),
    .cmd_act     (cmd_act),
    .den_act     (den_act),
    .cmd_sel     (cmd_sel)
  );

  bcc_drive u_drv (
    .clk         (clk),
    .rst         (rst),
    .mode_compat (mode_compat),
    .en_grant    (en_grant),
    .cmd_act     (cmd_act),
    .den_act     (den_act),
    .cmd_sel     (cmd_sel),
    .cmd_n       (cmd_n),
    .den         (den),
    .cmd_oe      (cmd_oe)
  );

  assign iack_n = cmd_n[CMD_IACK];
  assign iord_n = cmd_n[CMD_IORD];
  assign iowr_n = cmd_n[CMD_IOWR];
  assign mrd_n  = cmd_n[CMD_MRD];
  assign mwr_n  = cmd_n[CMD_MWR];
endmodule

// File: tb/test_buscmd_ctrl.sv
module test_buscmd_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst, mem_io, mode_compat, sel_latch, hold_cmd, rdy_n, en_grant;
  logic [1:0] st_n;
  logic ale, casc_en, den, dir_wr, cmd_oe, mrd_n, mwr_n, iord_n, iowr_n, iack_n;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  buscmd_ctrl i_buscmd_ctrl (
    .clk(clk), .rst(rst), .st_n(st_n), .mem_io(mem_io), .mode_compat(mode_compat),
    .sel_latch(sel_latch), .hold_cmd(hold_cmd), .rdy_n(rdy_n), .en_grant(en_grant),
    .ale(ale), .casc_en(casc_en), .den(den), .dir_wr(dir_wr), .cmd_oe(cmd_oe),
    .mrd_n(mrd_n), .mwr_n(mwr_n), .iord_n(iord_n), .iowr_n(iowr_n), .iack_n(iack_n)
  );

  // bit order: ale casc den dir oe mwr mrd iowr iord iack
  function automatic logic [9:0] ev(input logic a, input logic c, input logic d,
                                    input logic w, input logic o, input int k);
    logic [4:0] cn = 5'h1f;
    if (k >= 0) cn[k] = 1'b0;
    return {a, c, d, w, o, cn};
  endfunction

  task automatic chk(input string tag, input logic [9:0] exp);
    logic [9:0] act = {ale, casc_en, den, dir_wr, cmd_oe, mwr_n, mrd_n, iowr_n, iord_n, iack_n};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put_code(input logic [2:0] code);
    mem_io = code[2];
    st_n   = code[1:0];
  endtask

  task automatic t_reset();
    rst = 1'b1; rdy_n = 1'b0; st_n = 2'b00; mem_io = 1'b1; mode_compat = 1'b0;
    sel_latch = 1'b1; hold_cmd = 1'b0; en_grant = 1'b1;
    step(); step();
    chk("R12 reset idle", ev(0,0,0,1,1,-1));
    rst = 1'b0; rdy_n = 1'b1; st_n = 2'b11;
    step();
    chk("R12 after reset", ev(0,0,0,1,1,-1));
  endtask

  task automatic t_plain(input logic compat, input logic [2:0] code, input int k);
    logic wr = code[1];
    logic ia = (code == 3'b000);
    mode_compat = compat; en_grant = ~compat;
    step();
    put_code(code); step();
    chk("R2 ale at edge0", ev(1,ia,0,1,1,-1));
    st_n = 2'b11; step();
    chk("R3 dir at edge1", ev(0,0,0,wr,1,-1));
    step();
    if (!compat) begin
      chk("R4 R1 fast command edge2", ev(0,0,1,wr,1,k));
    end else begin
      chk("R5 compat edge2", ev(0,0,!wr,wr,1,-1));
      step();
      chk("R5 R1 compat command edge3", ev(0,0,1,wr,1,k));
    end
    rdy_n = 1'b0; step();
    chk("R7 ready ends cycle", ev(0,0,0,wr,1,-1));
    rdy_n = 1'b1; step();
    chk("R3 dir back high", ev(0,0,0,1,1,-1));
  endtask

  task automatic t_hold();
    mode_compat = 1'b0; en_grant = 1'b1; step();
    put_code(3'b101); step();
    st_n = 2'b11; step();
    hold_cmd = 1'b1; step();
    chk("R6 hold edge2, den unaffected", ev(0,0,1,0,1,-1));
    step();
    chk("R6 hold edge3", ev(0,0,1,0,1,-1));
    hold_cmd = 1'b0; step();
    chk("R6 release starts command", ev(0,0,1,0,1,3));
    rdy_n = 1'b0; step(); rdy_n = 1'b1; step();
    chk("R6 end idle", ev(0,0,0,1,1,-1));
  endtask

  task automatic t_ready_early();
    mode_compat = 1'b1; en_grant = 1'b0; step();
    put_code(3'b001); step();
    st_n = 2'b11; step();
    step();
    chk("R7 compat edge2 no command", ev(0,0,1,0,1,-1));
    rdy_n = 1'b0; step();
    chk("R7 early ready, no command", ev(0,0,0,0,1,-1));
    rdy_n = 1'b1; step();
    chk("R7 back to idle", ev(0,0,0,1,1,-1));
    step();
    chk("R7 command never issued", ev(0,0,0,1,1,-1));
  endtask

  task automatic t_desel();
    mode_compat = 1'b0; en_grant = 1'b1; step();
    put_code(3'b110); step();
    st_n = 2'b11; sel_latch = 1'b0; step();
    chk("R8 edge1 deselected", ev(0,0,0,1,1,-1));
    sel_latch = 1'b1; step();
    chk("R8 latched select keeps quiet", ev(0,0,0,1,1,-1));
    step();
    chk("R8 still quiet", ev(0,0,0,1,1,-1));
    rdy_n = 1'b0; step(); rdy_n = 1'b1; step();
    chk("R8 idle", ev(0,0,0,1,1,-1));
  endtask

  task automatic t_grant();
    mode_compat = 1'b1; en_grant = 1'b1; step();
    chk("R9 no grant, tristated", ev(0,0,0,1,0,-1));
    put_code(3'b101); step();
    chk("R9 ale while released", ev(1,0,0,1,0,-1));
    st_n = 2'b11; step(); step();
    chk("R9 edge2 den held low", ev(0,0,0,0,0,-1));
    step();
    chk("R9 edge3 command released", ev(0,0,0,0,0,-1));
    en_grant = 1'b0; step();
    chk("R9 grant drives command", ev(0,0,1,0,1,3));
    rdy_n = 1'b0; step(); rdy_n = 1'b1; step();
    mode_compat = 1'b0; en_grant = 1'b0; step();
    put_code(3'b010); step();
    st_n = 2'b11; step(); step();
    chk("R9 fast enable low forces off", ev(0,0,0,1,1,-1));
    en_grant = 1'b1; step();
    chk("R9 fast enable restores", ev(0,0,1,1,1,2));
    rdy_n = 1'b0; step(); rdy_n = 1'b1; step();
    chk("R9 idle", ev(0,0,0,1,1,-1));
  endtask

  task automatic t_halt();
    mode_compat = 1'b0; en_grant = 1'b1; step();
    put_code(3'b100); hold_cmd = 1'b1; rdy_n = 1'b0; sel_latch = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R10 halt ignored", ev(0,0,0,1,1,-1));
    end
    put_code(3'b111); step();
    chk("R10 idle code ignored", ev(0,0,0,1,1,-1));
    hold_cmd = 1'b0; rdy_n = 1'b1; sel_latch = 1'b1;
  endtask

  task automatic t_pipe();
    mode_compat = 1'b0; en_grant = 1'b1; step();
    put_code(3'b101); step();
    st_n = 2'b11; step(); step();
    chk("R11 first command", ev(0,0,1,0,1,3));
    rdy_n = 1'b0; put_code(3'b110); step();
    chk("R11 new ale, old dir kept", ev(1,0,0,0,1,-1));
    rdy_n = 1'b1; st_n = 2'b11; step();
    chk("R11 dir turns at edge1", ev(0,0,0,1,1,-1));
    step();
    chk("R11 second command", ev(0,0,1,1,1,4));
    rdy_n = 1'b0; step(); rdy_n = 1'b1; step();
    chk("R11 idle", ev(0,0,0,1,1,-1));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_plain(1'b0, 3'b000, 0);
    t_plain(1'b0, 3'b001, 1);
    t_plain(1'b0, 3'b010, 2);
    t_plain(1'b0, 3'b101, 3);
    t_plain(1'b0, 3'b110, 4);
    t_plain(1'b1, 3'b101, 3);
    t_plain(1'b1, 3'b110, 4);
    t_plain(1'b1, 3'b000, 0);
    t_hold();
    t_ready_early();
    t_desel();
    t_grant();
    t_halt();
    t_plain(1'b0, 3'b101, 3);
    t_pipe();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule